// File: doc/BRIEF.md
# Analog Input Scaling and Formatting Unit

This block sits behind a multichannel 12-bit converter. It turns each raw reading into an engineering value for one of up to 16 channels. Every channel holds a lower and an upper limit. Each limit is a sign bit plus a four-digit BCD magnitude, loaded through a configuration write port. The block always decodes a limit as BCD, whatever output format is selected. It maps the reading linearly from the full raw span onto the channel's limit span and truncates toward zero. It then encodes the result as BCD, two's complement or signed-magnitude binary.

Only one reading is in flight at a time. A reading is accepted when `in_valid` and `in_ready` are both high. The result appears on a one-cycle `out_valid` strobe, together with its channel number. Four per-channel bitmaps record:
- whether the last reading sat at the bottom or the top of the raw span;
- whether the last result was negative;
- whether a result has arrived that the host has not yet read.

The host clears the last of these with a read strobe.

Top module: `anin_scaler`

## Requirements
- R1: After reset all four bitmaps are zero, `out_valid` is 0 and `in_ready` is 1. Every channel has lower limit +0000 and upper limit +4095, so a raw reading r is reported as the value r.
- R2: The result is the sign-preserving truncation toward zero of (L*(4095-r) + U*r)/4095, where L and U are the channel's limits. A limit's magnitude is decoded from `cfg_bcd` as four BCD digits: bits 15:12 are thousands, 11:8 hundreds, 7:4 tens and 3:0 units. `cfg_neg`=1 makes the limit negative.
- R3: A reading accepted at clock edge E produces `out_valid` high for exactly one cycle after edge E+27, with `out_chan` equal to the accepted channel. `in_ready` is low from edge E+1 until edge E+27 and high again after it. A reading offered while `in_ready` is low is ignored.
- R4: `fmt_sel` is sampled when a reading is accepted and sets the encoding of `out_data`:
  - 00: the magnitude as four BCD digits;
  - 10: 16-bit two's complement;
  - 11: bit 15 is the sign and bits 14:0 are the magnitude;
  - 01 (reserved): all zeros.
- R5: Bit n of `sign_map` equals 1 exactly when the last result for channel n was below zero.
- R6: Bit n of `under_map` is set when channel n's last reading was 0. Bit n of `over_map` is set when that reading was 4095. A later in-range reading of channel n clears both bits.
- R7: Bit n of `fresh_map` sets when a result for channel n is produced. It clears after a cycle with `rd_strobe`=1 and `rd_chan`=n. If both happen in the same cycle, the bit stays set.
- R8: A configuration write with `cfg_upper`=1 replaces the upper limit and with `cfg_upper`=0 the lower limit, of channel `cfg_chan` only. It applies to readings accepted on later edges.
- R9: Channel n (0 to 15) uses bit n of every bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Limit write enable |
| cfg_chan | input | 4 | Channel whose limit is written |
| cfg_upper | input | 1 | 1 selects the upper limit, 0 the lower |
| cfg_neg | input | 1 | Limit is negative |
| cfg_bcd | input | 16 | Limit magnitude, four BCD digits |
| fmt_sel | input | 2 | Output encoding code |
| in_valid | input | 1 | Raw reading offered |
| in_chan | input | 4 | Channel of the raw reading |
| in_raw | input | 12 | Raw converter reading |
| in_ready | output | 1 | Unit can accept a reading |
| rd_strobe | input | 1 | Host read of a channel |
| rd_chan | input | 4 | Channel being read |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 4 | Channel of the result |
| out_data | output | 16 | Formatted result |
| under_map | output | 16 | Reading at bottom of span, per channel |
| over_map | output | 16 | Reading at top of span, per channel |
| sign_map | output | 16 | Result negative, per channel |
| fresh_map | output | 16 | Unread result present, per channel |

## Verification
The hardest case to reach from the ports is a host read that clears a channel's fresh bit in the very cycle a new result for that channel is written. A close second is a reading, together with a format change, offered while a division is still running.

The bench counts cycles from the accept edge. It raises the read strobe in the cycle just before edge 27, so the strobe meets the result. In another run it drives a second reading and the reserved format code at cycle 5. It then checks that neither leaves a trace on the output or on the bitmaps.

// File: rtl/anin_pkg.sv
package anin_pkg;
  typedef struct packed {
    logic        neg;
    logic [15:0] bcd;
  } lim_t;

  localparam logic [1:0] FMT_BCD = 2'b00;
  localparam logic [1:0] FMT_RSV = 2'b01;
  localparam logic [1:0] FMT_TWO = 2'b10;
  localparam logic [1:0] FMT_SGM = 2'b11;

  function automatic int bcd_to_int(input logic [15:0] b);
    return int'(b[15:12]) * 1000 + int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [15:0] int_to_bcd(input int v);
    logic [15:0] r;
    int rest;
    r = '0;
    rest = (v > 9999) ? 9999 : v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(rest % 10);
      rest = rest / 10;
    end
    return r;
  endfunction

  function automatic logic [15:0] encode(input logic [1:0] f, input logic neg,
                                         input logic [13:0] mag);
    logic [15:0] m16;
    m16 = {2'b00, mag};
    case (f)
      FMT_BCD: return int_to_bcd(int'(mag));
      FMT_TWO: return neg ? (16'd0 - m16) : m16;
      FMT_SGM: return {neg, m16[14:0]};
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/anin_limit_store.sv
module anin_limit_store
  import anin_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 4,
  parameter logic [15:0] UP_DEFAULT = 16'h4095
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wchan,
  input  logic          wupper,
  input  lim_t          wval,
  input  logic [CW-1:0] rchan,
  output lim_t          lo,
  output lim_t          hi
);
  lim_t lo_q [NCH];
  lim_t hi_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '{neg: 1'b0, bcd: 16'h0000};
        hi_q[g] <= '{neg: 1'b0, bcd: UP_DEFAULT};
      end else if (we && wchan == CW'(g)) begin
        if (wupper) hi_q[g] <= wval;
        else        lo_q[g] <= wval;
      end
    end
  end

  assign lo = lo_q[rchan];
  assign hi = hi_q[rchan];
endmodule

// File: rtl/anin_seq_div.sv
module anin_seq_div #(
  parameter int NW      = 26,
  parameter int RW      = 12,
  parameter int DIVISOR = 4095
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CNT_W = $clog2(NW);

  logic [NW-1:0]    work;
  logic [RW-1:0]    rem;
  logic [CNT_W-1:0] cnt;
  logic [RW:0]      rem_sh;
  logic             ge;
  logic [RW-1:0]    rem_n;
  logic [NW-1:0]    work_n;

  always_comb begin
    rem_sh = {rem, work[NW-1]};
    ge     = rem_sh >= (RW+1)'(DIVISOR);
    rem_n  = ge ? RW'(rem_sh - (RW+1)'(DIVISOR)) : RW'(rem_sh);
    work_n = {work[NW-2:0], ge};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0; rem <= '0; cnt <= '0;
      busy <= 1'b0; done <= 1'b0; quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        work <= dividend; rem <= '0; cnt <= '0; busy <= 1'b1;
      end else if (busy) begin
        work <= work_n; rem <= rem_n; cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(NW-1)) begin
          busy <= 1'b0; done <= 1'b1; quotient <= work_n;
        end
      end
    end
  end

  // R2: partial remainder stays below the divisor throughout the divide
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < RW'(DIVISOR)));
  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/anin_status_map.sv
module anin_status_map #(
  parameter int NCH = 16,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd,
  input  logic [CW-1:0]  upd_chan,
  input  logic           upd_under,
  input  logic           upd_over,
  input  logic           upd_neg,
  input  logic           clr,
  input  logic [CW-1:0]  clr_chan,
  output logic [NCH-1:0] under_map,
  output logic [NCH-1:0] over_map,
  output logic [NCH-1:0] sign_map,
  output logic [NCH-1:0] fresh_map
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      under_map <= '0; over_map <= '0; sign_map <= '0; fresh_map <= '0;
    end else begin
      if (clr) fresh_map[clr_chan] <= 1'b0;
      if (upd) begin
        under_map[upd_chan] <= upd_under;
        over_map[upd_chan]  <= upd_over;
        sign_map[upd_chan]  <= upd_neg;
        fresh_map[upd_chan] <= 1'b1;
      end
    end
  end

  // R7: a produced result always leaves its fresh bit set
  assert_fresh_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> fresh_map[$past(upd_chan)]);
  // R7: a read with no colliding result clears the bit
  assert_fresh_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(upd && upd_chan == clr_chan)) |=> !fresh_map[$past(clr_chan)]);
  // R6: a channel is never flagged at both ends of the span
  assert_ends_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (under_map & over_map) == '0);
endmodule

// File: rtl/anin_scaler.sv
module anin_scaler
  import anin_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int RAW_W = 12,
  parameter int DW    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_chan,
  input  logic               cfg_upper,
  input  logic               cfg_neg,
  input  logic [15:0]        cfg_bcd,
  input  logic [1:0]         fmt_sel,
  input  logic               in_valid,
  input  logic [$clog2(NCH)-1:0] in_chan,
  input  logic [RAW_W-1:0]   in_raw,
  output logic               in_ready,
  input  logic               rd_strobe,
  input  logic [$clog2(NCH)-1:0] rd_chan,
  output logic               out_valid,
  output logic [$clog2(NCH)-1:0] out_chan,
  output logic [DW-1:0]      out_data,
  output logic [NCH-1:0]     under_map,
  output logic [NCH-1:0]     over_map,
  output logic [NCH-1:0]     sign_map,
  output logic [NCH-1:0]     fresh_map
);
  localparam int CW      = $clog2(NCH);
  localparam int RAW_MAX = (1 << RAW_W) - 1;
  localparam int LIM_MAX = 9999;
  localparam int NUM_W   = $clog2(LIM_MAX * RAW_MAX + 1);
  localparam int MAG_W   = 14;

  logic          accept;
  logic          pend;
  lim_t          lo, hi;
  int            lo_i, hi_i, num_i, mag_i;
  logic [NUM_W-1:0] dividend;
  logic          div_busy, div_done;
  logic [NUM_W-1:0] quotient;
  logic          res_neg;
  logic          neg_q, under_q, over_q;
  logic [1:0]    fmt_q;
  logic [CW-1:0] chan_q;

  assign in_ready = !pend;
  assign accept   = in_valid && in_ready;

  anin_limit_store #(.NCH(NCH), .CW(CW), .UP_DEFAULT(int_to_bcd(RAW_MAX))) u_lim (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wchan(cfg_chan), .wupper(cfg_upper),
    .wval('{neg: cfg_neg, bcd: cfg_bcd}), .rchan(in_chan), .lo(lo), .hi(hi));

  // numerator L*(max-r) + U*r, limits decoded from BCD at use
  always_comb begin
    lo_i  = lo.neg ? -bcd_to_int(lo.bcd) : bcd_to_int(lo.bcd);
    hi_i  = hi.neg ? -bcd_to_int(hi.bcd) : bcd_to_int(hi.bcd);
    num_i = lo_i * (RAW_MAX - int'(in_raw)) + hi_i * int'(in_raw);
    mag_i = (num_i < 0) ? -num_i : num_i;
    dividend = NUM_W'(mag_i);
  end

  anin_seq_div #(.NW(NUM_W), .RW(RAW_W), .DIVISOR(RAW_MAX)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept), .dividend(dividend),
    .busy(div_busy), .done(div_done), .quotient(quotient));

  assign res_neg = neg_q && (quotient != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; neg_q <= 1'b0; under_q <= 1'b0; over_q <= 1'b0;
      fmt_q <= FMT_BCD; chan_q <= '0;
      out_valid <= 1'b0; out_chan <= '0; out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        pend    <= 1'b1;
        neg_q   <= (num_i < 0);
        under_q <= (in_raw == '0);
        over_q  <= (in_raw == RAW_W'(RAW_MAX));
        fmt_q   <= fmt_sel;
        chan_q  <= in_chan;
      end
      if (div_done) begin
        pend      <= 1'b0;
        out_valid <= 1'b1;
        out_chan  <= chan_q;
        out_data  <= DW'(encode(fmt_q, res_neg, quotient[MAG_W-1:0]));
      end
    end
  end

  anin_status_map #(.NCH(NCH), .CW(CW)) u_stat (
    .clk(clk), .rst_n(rst_n), .upd(div_done), .upd_chan(chan_q),
    .upd_under(under_q), .upd_over(over_q), .upd_neg(res_neg),
    .clr(rd_strobe), .clr_chan(rd_chan),
    .under_map(under_map), .over_map(over_map), .sign_map(sign_map),
    .fresh_map(fresh_map));

  // R3: the unit stops accepting right after it takes a reading
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R3: each result is a one-cycle strobe
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R3: the divider runs only while a reading is pending
  assert_div_in_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> pend);
  // R4: the signed-magnitude field never holds more than the limit range
  assert_sgm_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt_q == FMT_SGM) |-> (out_data[14:0] <= 15'(LIM_MAX)));
  // R5: the sign bit of a new result matches the sign field it was encoded with
  assert_sign_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt_q == FMT_SGM) |-> (out_data[15] == sign_map[out_chan]));
endmodule

// File: tb/anin_scaler_bench.sv
module anin_scaler_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0, cfg_upper = 0, cfg_neg = 0;
  logic [3:0] cfg_chan = 0;
  logic [15:0] cfg_bcd = 0;
  logic [1:0] fmt_sel = 0;
  logic in_valid = 0;
  logic [3:0] in_chan = 0;
  logic [11:0] in_raw = 0;
  logic in_ready;
  logic rd_strobe = 0;
  logic [3:0] rd_chan = 0;
  logic out_valid;
  logic [3:0] out_chan;
  logic [15:0] out_data, under_map, over_map, sign_map, fresh_map;

  int n_vec = 0, n_bad = 0;
  int lo_m[16], hi_m[16];
  logic [15:0] m_under = 0, m_over = 0, m_sign = 0, m_fresh = 0;

  always #2 clk = ~clk;

  anin_scaler u_anin_scaler (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_upper(cfg_upper), .cfg_neg(cfg_neg), .cfg_bcd(cfg_bcd), .fmt_sel(fmt_sel),
    .in_valid(in_valid), .in_chan(in_chan), .in_raw(in_raw), .in_ready(in_ready),
    .rd_strobe(rd_strobe), .rd_chan(rd_chan), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data), .under_map(under_map),
    .over_map(over_map), .sign_map(sign_map), .fresh_map(fresh_map));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic check_maps(input string tag);
    chk(under_map == m_under, {tag, " R6 under"}, int'(under_map), int'(m_under));
    chk(over_map  == m_over,  {tag, " R6 over"},  int'(over_map),  int'(m_over));
    chk(sign_map  == m_sign,  {tag, " R5 sign"},  int'(sign_map),  int'(m_sign));
    chk(fresh_map == m_fresh, {tag, " R7 fresh"}, int'(fresh_map), int'(m_fresh));
  endtask

  function automatic int exp_word(input logic [1:0] f, input int q);
    int mag;
    mag = (q < 0) ? -q : q;
    case (f)
      2'b00: return ((mag / 1000) << 12) | (((mag / 100) % 10) << 8) |
                    (((mag / 10) % 10) << 4) | (mag % 10);
      2'b10: return q & 16'hFFFF;
      2'b11: return ((q < 0) ? 32'h8000 : 0) | mag;
      default: return 0;
    endcase
  endfunction

  // bcd word from decimal magnitude, neg flag
  task automatic cfg(input int ch, input bit up, input int val);
    int mag;
    mag = (val < 0) ? -val : val;
    cfg_we = 1; cfg_chan = 4'(ch); cfg_upper = up; cfg_neg = (val < 0);
    cfg_bcd = 16'(((mag / 1000) << 12) | (((mag / 100) % 10) << 8) |
                  (((mag / 10) % 10) << 4) | (mag % 10));
    step();
    cfg_we = 0;
    if (up) hi_m[ch] = val; else lo_m[ch] = val;
  endtask

  task automatic send(input int ch, input int raw, input logic [1:0] f,
                      input int rd_ch, input bit inject, input string tag);
    int q;
    q = (lo_m[ch] * (4095 - raw) + hi_m[ch] * raw) / 4095;
    in_valid = 1; in_chan = 4'(ch); in_raw = 12'(raw); fmt_sel = f;
    for (int k = 0; k <= 27; k++) begin
      step();
      if (k == 0) in_valid = 0;
      if (inject && k == 5) begin
        in_valid = 1; in_chan = 4'd7; in_raw = 12'd0; fmt_sel = 2'b01;
      end
      if (inject && k == 6) in_valid = 0;
      if (rd_ch >= 0 && k == 26) begin rd_strobe = 1; rd_chan = 4'(rd_ch); end
      if (rd_ch >= 0 && k == 27) rd_strobe = 0;
      if (k < 27) begin
        if (k == 1 || k == 26) chk(in_ready == 0, {tag, " R3 busy"}, int'(in_ready), 0);
        if (out_valid) chk(0, {tag, " R3 early valid"}, 1, 0);
      end
    end
    m_under[ch] = (raw == 0); m_over[ch] = (raw == 4095);
    m_sign[ch] = (q < 0); m_fresh[ch] = 1;
    chk(out_valid == 1, {tag, " R3 valid"}, int'(out_valid), 1);
    chk(in_ready == 1, {tag, " R3 ready"}, int'(in_ready), 1);
    chk(int'(out_chan) == ch, {tag, " R3 chan"}, int'(out_chan), ch);
    chk(int'(out_data) == exp_word(f, q), {tag, " R2 R4 data"}, int'(out_data), exp_word(f, q));
    check_maps(tag);
    fmt_sel = f;
    step();
    chk(out_valid == 0, {tag, " R3 pulse"}, int'(out_valid), 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin lo_m[i] = 0; hi_m[i] = 4095; end
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    chk(in_ready == 1, "R1 ready", int'(in_ready), 1);
    chk(out_valid == 0, "R1 valid", int'(out_valid), 0);
    check_maps("R1");
    // R1 R2 default passthrough, BCD output
    send(0, 1234, 2'b00, -1, 0, "R1 passthrough");
    // R6 span ends, R9 bit placement
    send(1, 0, 2'b10, -1, 0, "R6 bottom");
    send(1, 4095, 2'b10, -1, 0, "R6 top");
    send(1, 100, 2'b10, -1, 0, "R6 in range");
    send(15, 4095, 2'b11, -1, 0, "R9 ch15");
    // R8 negative lower / positive upper on channel 2
    cfg(2, 0, -500);
    cfg(2, 1, 1500);
    send(2, 0, 2'b10, -1, 0, "R2 neg twos");
    send(2, 2048, 2'b11, -1, 0, "R2 mid sgm");
    send(2, 1000, 2'b11, -1, 0, "R2 trunc sgm");
    send(2, 1000, 2'b00, -1, 0, "R4 bcd neg");
    send(2, 10, 2'b10, -1, 0, "R2 trunc twos");
    send(2, 3000, 2'b01, -1, 0, "R4 reserved");
    // R8 other channel untouched
    send(3, 777, 2'b00, -1, 0, "R8 untouched");
    // R7 read clears fresh
    rd_strobe = 1; rd_chan = 4'd0;
    m_fresh[0] = 0;
    step();
    rd_strobe = 0;
    check_maps("R7 read clear");
    // R7 read colliding with new result for same channel: stays set
    send(3, 10, 2'b10, 3, 0, "R7 collide");
    // R3 R4 reading and format change during busy ignored
    send(4, 2000, 2'b10, -1, 1, "R3 inject");
    for (int i = 0; i < 40; i++) begin
      step();
      if (out_valid) chk(0, "R3 ignored reading produced output", 1, 0);
    end
    check_maps("R3 after inject");
    // R8 upper negative, lower positive (descending map)
    cfg(5, 0, 9999);
    cfg(5, 1, -9999);
    send(5, 4095, 2'b11, -1, 0, "R8 descending top");
    send(5, 2047, 2'b10, -1, 0, "R8 descending mid");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule